// File: doc/BRIEF.md
# Frame Geometry Parameter Bank with Frame-Aligned Commit

This block holds the run-time geometry of a video pipeline: the active frame width, the active frame height and a hold flag that freezes the output on its current frame. A host changes these values while video is flowing. It writes them over a simple bus that has a write strobe, a byte address and write data. The read data is registered.

Host writes never reach the datapath directly. They land in a set of staging registers. The host then sets a commit flag. On the next input frame-start pulse, the staged width and height move into the working registers and the commit flag clears itself. The host polls the flag to learn when the staging registers are free again. While the flag is set, every host write is refused, so a half-built configuration can never mix with the one in flight. The hold flag moves to a second stage at the same commit, and it reaches the datapath only at the next output frame start.

There is no pixel stream through this block, so every pin is a plain control or status signal. The bus has no back-pressure: a write either lands in the cycle it is presented or is dropped, and the commit flag is the only handshake.

Top module: `vpb_param_bank`

## Requirements
- R1: After reset, width and height read back and drive out as the configured maximum minus one. Hold and commit read as 0, and the hold output is 0.
- R2: The register is selected by byte address bits [4:2]: 0 is width, 1 is height, 2 is hold (bit 0) and 3 is commit (bit 0). With a 32-bit bus, address bits [1:0] are ignored. With a 16-bit bus, bit 0 is ignored and bit 1 selects the upper half, which reads 0 and ignores writes.
- R3: A write to width or height stores the value clamped to the range [63, maximum-1]. The stored value is the dimension minus one.
- R4: Read data in a cycle reflects the address presented in the previous cycle. Word indices 4 to 7 read 0, and bits above bit 0 of the hold and commit registers read 0.
- R5: Writes to staging registers, and input frame-start pulses while no commit is pending, leave the width, height and hold outputs unchanged.
- R6: Writing 1 to bit 0 of the commit register sets a pending commit, which reads back as 1. Writing 0 while nothing is pending has no effect.
- R7: While a commit is pending, all writes are ignored, including writes to the commit register.
- R8: On the first input frame-start pulse with a commit pending, the width and height outputs take the staged values in the next cycle, and the commit flag reads 0 from then on.
- R9: A register not written before a commit carries its previous staged value into the working copy.
- R10: The committed hold value is staged and drives the hold output only from the next output frame-start pulse. A pulse in the same cycle as the commit still forwards the older staged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | ADDR_W | Host byte address |
| cfg_wdata | input | DATA_W | Host write data |
| cfg_rdata | output | DATA_W | Registered read data |
| sof_in | input | 1 | Input frame-start pulse |
| sof_out | input | 1 | Output frame-start pulse |
| act_width | output | DIM_W | Working width minus one |
| act_height | output | DIM_W | Working height minus one |
| act_hold | output | 1 | Working hold flag |

## Verification
Directed cases start from reset. They then check:
- values below the minimum and above the maximum, to separate clamping from plain storage;
- addresses with their low bits set, and addresses in the unmapped words, to separate register decoding from address aliasing;
- writes made while a commit is pending, to show the lockout is enforced;
- an output frame-start pulse in the same cycle as the commit, to separate the staged hold path from a direct copy.

After that, a long random mix follows. It interleaves writes, reads, commits and sparse frame pulses on both sides. Its purpose is to catch ordering faults between the lockout, the frame-aligned apply and the two-stage hold path, which directed cases alone tend to miss.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
  typedef enum logic [2:0] {
    SEL_WIDTH  = 3'd0,
    SEL_HEIGHT = 3'd1,
    SEL_HOLD   = 3'd2,
    SEL_COMMIT = 3'd3,
    SEL_NONE   = 3'd4
  } vpb_sel_e;

  localparam int unsigned MIN_DIM_M1 = 63;
endpackage

// File: rtl/vpb_decode.sv
module vpb_decode
  import vpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output vpb_sel_e          sel,
  output logic              hi_half
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  generate
    if (DATA_W == 16) begin : g_bus16
      logic unused_lane;
      assign unused_lane = addr[0];
      assign hi_half = addr[1];
    end else begin : g_bus32
      logic unused_lane;
      assign unused_lane = ^addr[1:0];
      assign hi_half = 1'b0;
    end
  endgenerate

  always_comb begin
    if (idx == IDX_W'(0))      sel = SEL_WIDTH;
    else if (idx == IDX_W'(1)) sel = SEL_HEIGHT;
    else if (idx == IDX_W'(2)) sel = SEL_HOLD;
    else if (idx == IDX_W'(3)) sel = SEL_COMMIT;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/vpb_shadow.sv
module vpb_shadow
  import vpb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM_W  = 16,
  parameter int unsigned MAX_W  = 1920,
  parameter int unsigned MAX_H  = 1080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  vpb_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sof_in,
  output logic [DIM_W-1:0]  sh_width,
  output logic [DIM_W-1:0]  sh_height,
  output logic              sh_hold,
  output logic              pending,
  output logic              apply
);
  localparam logic [DIM_W-1:0] W_TOP = DIM_W'(MAX_W - 1);
  localparam logic [DIM_W-1:0] H_TOP = DIM_W'(MAX_H - 1);
  localparam logic [DIM_W-1:0] D_MIN = DIM_W'(MIN_DIM_M1);

  function automatic logic [DIM_W-1:0] clamp_dim(input logic [DATA_W-1:0] v,
                                                 input logic [DIM_W-1:0]  top);
    if (v < DATA_W'(D_MIN))     return D_MIN;
    else if (v > DATA_W'(top))  return top;
    else                        return v[DIM_W-1:0];
  endfunction

  logic open_wr;
  assign open_wr = wr_en && !pending;
  assign apply   = pending && sof_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_width  <= W_TOP;
      sh_height <= H_TOP;
      sh_hold   <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (open_wr) begin
        case (sel)
          SEL_WIDTH:  sh_width  <= clamp_dim(wdata, W_TOP);
          SEL_HEIGHT: sh_height <= clamp_dim(wdata, H_TOP);
          SEL_HOLD:   sh_hold   <= wdata[0];
          SEL_COMMIT: pending   <= wdata[0];
          default: ;
        endcase
      end
      if (apply) pending <= 1'b0;
    end
  end

  AST_LOCK_STAGING: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> ($stable(sh_width) && $stable(sh_height) && $stable(sh_hold))); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !sof_in) |=> pending); // R7
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && sof_in) |=> !pending); // R8
  AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_width >= D_MIN) && (sh_width <= W_TOP) && (sh_height >= D_MIN) && (sh_height <= H_TOP)); // R3
endmodule

// File: rtl/vpb_active.sv
module vpb_active #(
  parameter int unsigned DIM_W = 16,
  parameter int unsigned MAX_W = 1920,
  parameter int unsigned MAX_H = 1080
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [DIM_W-1:0] sh_width,
  input  logic [DIM_W-1:0] sh_height,
  input  logic             sh_hold,
  input  logic             sof_out,
  output logic [DIM_W-1:0] act_width,
  output logic [DIM_W-1:0] act_height,
  output logic             act_hold
);
  logic hold_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_width  <= DIM_W'(MAX_W - 1);
      act_height <= DIM_W'(MAX_H - 1);
      hold_stage <= 1'b0;
      act_hold   <= 1'b0;
    end else begin
      if (apply) begin
        act_width  <= sh_width;
        act_height <= sh_height;
        hold_stage <= sh_hold;
      end
      if (sof_out) act_hold <= hold_stage;
    end
  end

  AST_DIM_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(act_width) && $stable(act_height))); // R5
  AST_DIM_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> ((act_width == $past(sh_width)) && (act_height == $past(sh_height)))); // R8
  AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_out |=> $stable(act_hold)); // R10
endmodule

// File: rtl/vpb_param_bank.sv
module vpb_param_bank
  import vpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM_W  = 16,
  parameter int unsigned MAX_W  = 1920,
  parameter int unsigned MAX_H  = 1080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              sof_in,
  input  logic              sof_out,
  output logic [DIM_W-1:0]  act_width,
  output logic [DIM_W-1:0]  act_height,
  output logic              act_hold
);
  vpb_sel_e         sel;
  logic             hi_half;
  logic [DIM_W-1:0] sh_width;
  logic [DIM_W-1:0] sh_height;
  logic             sh_hold;
  logic             pending;
  logic             apply;
  logic [DATA_W-1:0] rd_word;

  vpb_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .addr(cfg_addr), .sel(sel), .hi_half(hi_half)
  );

  vpb_shadow #(.DATA_W(DATA_W), .DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && !hi_half), .sel(sel),
    .wdata(cfg_wdata), .sof_in(sof_in), .sh_width(sh_width),
    .sh_height(sh_height), .sh_hold(sh_hold), .pending(pending), .apply(apply)
  );

  vpb_active #(.DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_active (
    .clk(clk), .rst_n(rst_n), .apply(apply), .sh_width(sh_width),
    .sh_height(sh_height), .sh_hold(sh_hold), .sof_out(sof_out),
    .act_width(act_width), .act_height(act_height), .act_hold(act_hold)
  );

  always_comb begin
    rd_word = '0;
    if (!hi_half) begin
      case (sel)
        SEL_WIDTH:  rd_word = DATA_W'(sh_width);
        SEL_HEIGHT: rd_word = DATA_W'(sh_height);
        SEL_HOLD:   rd_word = DATA_W'(sh_hold);
        SEL_COMMIT: rd_word = DATA_W'(pending);
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rdata <= '0;
    else        cfg_rdata <= rd_word;
  end

  AST_FLAG_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_HOLD) || (sel == SEL_COMMIT)) |=> (cfg_rdata[DATA_W-1:1] == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> (cfg_rdata == '0)); // R4
endmodule

// File: tb/vpb_param_bank_test.sv
module vpb_param_bank_test;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DIM_W  = 16;
  localparam int unsigned MAX_W  = 1920;
  localparam int unsigned MAX_H  = 1080;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] cfg_rdata;
  logic              sof_in = 1'b0;
  logic              sof_out = 1'b0;
  logic [DIM_W-1:0]  act_width;
  logic [DIM_W-1:0]  act_height;
  logic              act_hold;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int unsigned m_w, m_h, a_w, a_h;
  bit m_hold, m_pend, stg_hold, a_hold;

  always #2 clk = ~clk;

  vpb_param_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W),
                   .MAX_W(MAX_W), .MAX_H(MAX_H)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sof_in(sof_in),
    .sof_out(sof_out), .act_width(act_width), .act_height(act_height),
    .act_hold(act_hold)
  );

  function automatic int unsigned clamp_ref(input logic [31:0] v, input int unsigned top);
    if (v < 32'd63) return 63;
    if (v > top) return top;
    return v;
  endfunction

  function automatic logic [31:0] read_ref(input logic [ADDR_W-1:0] a);
    case (a[4:2])
      3'd0: return m_w;
      3'd1: return m_h;
      3'd2: return {31'd0, m_hold};
      3'd3: return {31'd0, m_pend};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update the model, sample 1 ns after the edge
  task automatic step(input bit we, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                      input bit si, input bit so, input string tag);
    logic [31:0] exp_rd;
    int unsigned n_w, n_h, n_aw, n_ah;
    bit n_hold, n_pend, n_stg, n_ahold;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd; sof_in = si; sof_out = so;
    exp_rd = read_ref(a);
    n_w = m_w; n_h = m_h; n_hold = m_hold; n_pend = m_pend;
    n_aw = a_w; n_ah = a_h; n_stg = stg_hold; n_ahold = a_hold;
    if (we && !m_pend) begin
      case (a[4:2])
        3'd0: n_w = clamp_ref(wd, MAX_W - 1);
        3'd1: n_h = clamp_ref(wd, MAX_H - 1);
        3'd2: n_hold = wd[0];
        3'd3: n_pend = wd[0];
        default: ;
      endcase
    end
    if (m_pend && si) begin
      n_aw = m_w; n_ah = m_h; n_stg = m_hold; n_pend = 0;
    end
    if (so) n_ahold = stg_hold;
    m_w = n_w; m_h = n_h; m_hold = n_hold; m_pend = n_pend;
    a_w = n_aw; a_h = n_ah; stg_hold = n_stg; a_hold = n_ahold;
    @(posedge clk);
    #1;
    check(cfg_rdata == exp_rd, tag, "rdata", cfg_rdata, exp_rd);
    check(act_width == DIM_W'(a_w), tag, "act_width", 32'(act_width), a_w);
    check(act_height == DIM_W'(a_h), tag, "act_height", 32'(act_height), a_h);
    check(act_hold == a_hold, tag, "act_hold", 32'(act_hold), 32'(a_hold));
    cfg_we = 0; sof_in = 0; sof_out = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    m_w = MAX_W - 1; m_h = MAX_H - 1; m_hold = 0; m_pend = 0;
    a_w = MAX_W - 1; a_h = MAX_H - 1; stg_hold = 0; a_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step(0, 5'h00, 0, 0, 0, "R1");
    step(0, 5'h04, 0, 0, 0, "R1");
    step(0, 5'h08, 0, 0, 0, "R1");
    step(0, 5'h0C, 0, 0, 0, "R1");
    step(0, 5'h00, 0, 0, 0, "R1");
    // R3 clamping both sides
    step(1, 5'h00, 32'd5, 0, 0, "R3");
    step(0, 5'h00, 0, 0, 0, "R3");
    step(1, 5'h04, 32'h8000_0000, 0, 0, "R3");
    step(0, 5'h04, 0, 0, 0, "R3");
    step(1, 5'h04, 32'd63, 0, 0, "R3");
    step(0, 5'h04, 0, 0, 0, "R3");
    // R2 low address bits ignored
    step(1, 5'h03, 32'd300, 0, 0, "R2");
    step(0, 5'h02, 0, 0, 0, "R2");
    // R4 unmapped and narrow registers
    step(1, 5'h1F, 32'hFFFF_FFFF, 0, 0, "R4");
    step(0, 5'h14, 0, 0, 0, "R4");
    step(1, 5'h08, 32'hFFFF_FFFF, 0, 0, "R4");
    step(0, 5'h08, 0, 0, 0, "R4");
    // R5 staging does not reach outputs, sof_in without commit
    step(0, 5'h00, 0, 1, 0, "R5");
    step(0, 5'h00, 0, 0, 1, "R5");
    // R6 commit flag
    step(1, 5'h0C, 32'd0, 0, 0, "R6");
    step(0, 5'h0C, 0, 0, 0, "R6");
    step(1, 5'h0C, 32'd1, 0, 0, "R6");
    step(0, 5'h0C, 0, 0, 0, "R6");
    // R7 lockout
    step(1, 5'h00, 32'd400, 0, 0, "R7");
    step(1, 5'h08, 32'd0, 0, 0, "R7");
    step(1, 5'h0C, 32'd0, 0, 0, "R7");
    step(0, 5'h00, 0, 0, 0, "R7");
    step(0, 5'h0C, 0, 0, 0, "R7");
    // R8 apply on frame start; R10 same-cycle output frame keeps old hold
    step(0, 5'h0C, 0, 1, 1, "R8");
    step(0, 5'h0C, 0, 0, 0, "R8");
    step(0, 5'h08, 0, 0, 1, "R10");
    // R9 only height changed
    step(1, 5'h04, 32'd720, 0, 0, "R9");
    step(1, 5'h0C, 32'd1, 0, 0, "R9");
    step(0, 5'h00, 0, 1, 0, "R9");
    step(0, 5'h0C, 0, 0, 0, "R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [31:0] wd;
      logic [ADDR_W-1:0] a;
      r = $urandom;
      a = ADDR_W'($urandom);
      if (r[3:2] != 2'd0) a = {2'b00, r[5:4], a[1:0]};
      case (r[7:6])
        2'd0: wd = $urandom;
        2'd1: wd = 32'($urandom_range(0, 2200));
        default: wd = {31'd0, r[8]};
      endcase
      step(r[9] & r[10], a, wd, r[13:11] == 3'd0, r[16:14] == 3'd0, "R8");
    end
    finish_run();
  end
endmodule